// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index

This block turns the two phase signals of an incremental encoder, plus its index mark, into clean up/down count pulses for a downstream position counter. The filter clock comes from a programmable 8-bit divider running on the block clock. Each of the three inputs passes through a digital noise filter, which accepts a new level only after two agreeing samples on the filter clock. The filtered phases are then decoded at one, two or four counts per encoder cycle. When two phases change together, the block raises a sticky error flag. The index mark is brought out as a filtered level, and as an event aligned to the first count pulse that sees the mark active.

In direct mode the filter and the decoder are bypassed. Phase A acts as the count clock, counting on its rising edge, and phase B gives the direction. A host-controlled enable can block the phase inputs completely. The counter arithmetic and the host register interface are not part of this block. It only receives the divider value, the mode and the index settings as plain inputs. All inputs are taken to be synchronous to `clk_i`.

Top module: `quad_filter_decoder`

## Requirements
- R1: The divider reload value n is taken from `psc_val_i` in the cycle `psc_load_i` is high, and the divider restarts from it. After that, a filter tick occurs once every n+1 clock cycles. Reset leaves n = 0. In quadrature modes every count pulse on `count_o` lasts exactly n+1 clock cycles.
- R2: A filtered input takes a new level only when two consecutive filter ticks both sample that level. A pulse seen by a single tick produces no count.
- R3: With `mode_i` = 2'b11 (x4), every filtered change of A or B alone gives one count pulse. `up_o` = 1 when A leads B. The forward order of the {A,B} states is 00, 10, 11, 01.
- R4: With `mode_i` = 2'b10 (x2), only filtered changes of A give count pulses. Changes of B alone give none.
- R5: With `mode_i` = 2'b01 (x1), a count pulse is given only when A changes while filtered B is 0. This is one count per encoder cycle in each direction.
- R6: In quadrature modes, when filtered A and B change at the same tick, the error flag `err_o` is set and no count pulse is produced.
- R7: `err_o` stays set until `err_clr_i` is high. If an error is set in the same cycle as a clear, the set wins.
- R8: With `mode_i` = 2'b00 (direct), each rising edge of raw A gives a count pulse of one clock cycle, with `up_o` equal to raw B. No filtering is applied.
- R9: While `ab_en_i` is 0, no count pulse is produced and the error flag is not set.
- R10: `idx_o` shows the active level of the filtered index, refreshed on every filter tick. `idx_pol_i` = 1 makes high the active level, and `idx_pol_i` = 0 makes low the active level.
- R11: When `idx_en_i` = 1 in a quadrature mode, `idx_evt_o` pulses together with the first count pulse that sees the index active. It pulses once per index pulse, whether the pulse lasts a quarter or a half encoder cycle. When `idx_en_i` = 0, `idx_evt_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and filter source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc_load_i | input | 1 | Load the divider reload value |
| psc_val_i | input | 8 | Divider reload value n |
| mode_i | input | 2 | 00 direct, 01 x1, 10 x2, 11 x4 |
| ab_en_i | input | 1 | Phase input enable |
| a_i | input | 1 | Phase A, or count clock in direct mode |
| b_i | input | 1 | Phase B, or direction in direct mode |
| idx_i | input | 1 | Encoder index mark |
| idx_en_i | input | 1 | Enable the synchronised index event |
| idx_pol_i | input | 1 | Index active level (1 = high) |
| err_clr_i | input | 1 | Clear the error flag |
| count_o | output | 1 | Count pulse |
| up_o | output | 1 | Direction of the latest count (1 = up) |
| err_o | output | 1 | Sticky illegal-transition flag |
| idx_o | output | 1 | Filtered index active level |
| idx_evt_o | output | 1 | Index event aligned to a count pulse |

## Verification
Two functions can fall in the same cycle: an illegal double-phase transition setting the error flag, and a host clear of that flag. The bench makes them collide by sweeping a one-cycle clear pulse over a range of offsets around the tick that decodes the illegal step. A behavioural model, which applies set-over-clear, judges every cycle. The index event and an ordinary count pulse also coincide by design. Quarter-cycle and half-cycle index marks check that only the first count inside each mark is tagged.

// File: rtl/qdf_pkg.sv
package qdf_pkg;
  typedef enum logic [1:0] {
    QM_DIRECT = 2'b00,
    QM_X1     = 2'b01,
    QM_X2     = 2'b10,
    QM_X4     = 2'b11
  } qmode_e;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
  localparam int unsigned CH_IDX = 2;
endpackage

// File: rtl/qdf_prescaler.sv
module qdf_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         tick_o
);
  logic [W-1:0] n_q, cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      n_q   <= value_i;
      cnt_q <= value_i;
    end else if (tick_o) begin
      cnt_q <= n_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1
  psc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_q);

  // R1
  psc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (cnt_q == $past(n_q)));
endmodule

// File: rtl/qdf_glitch_filter.sv
module qdf_glitch_filter #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] flt_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic smp_q, flt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q <= 1'b0;
        flt_q <= 1'b0;
      end else if (tick_i) begin
        smp_q <= raw_i[g];
        if (raw_i[g] == smp_q) flt_q <= raw_i[g];
      end
    end

    assign flt_o[g] = flt_q;

    // R2
    flt_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i || (raw_i[g] != smp_q)) |=> $stable(flt_o[g]));
  end
endmodule

// File: rtl/qdf_decoder.sv
module qdf_decoder
  import qdf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  qmode_e mode_i,
  input  logic   ab_en_i,
  input  logic   a_raw_i,
  input  logic   b_raw_i,
  input  logic   a_flt_i,
  input  logic   b_flt_i,
  input  logic   idx_flt_i,
  input  logic   idx_en_i,
  input  logic   idx_pol_i,
  input  logic   err_clr_i,
  output logic   count_o,
  output logic   up_o,
  output logic   err_o,
  output logic   idx_o,
  output logic   idx_evt_o
);
  logic a_pv_q, b_pv_q, a_raw_q;
  logic cnt_q, up_q, err_q, idx_q, evt_q, fired_q;
  logic da, db, quad, illegal, dir, hit, q_cnt, q_evt, act, d_cnt, err_set;

  assign da      = a_flt_i ^ a_pv_q;
  assign db      = b_flt_i ^ b_pv_q;
  assign quad    = (mode_i != QM_DIRECT);
  assign illegal = da & db;
  assign dir     = da ? (a_flt_i ^ b_flt_i) : ~(a_flt_i ^ b_flt_i);
  assign act     = idx_pol_i ? idx_flt_i : ~idx_flt_i;

  always_comb begin
    unique case (mode_i)
      QM_X4:   hit = da ^ db;
      QM_X2:   hit = da & ~db;
      QM_X1:   hit = da & ~db & ~b_flt_i;
      default: hit = 1'b0;
    endcase
  end

  assign q_cnt   = ab_en_i & hit;
  assign q_evt   = idx_en_i & act & q_cnt & ~fired_q;
  assign d_cnt   = ab_en_i & a_raw_i & ~a_raw_q;
  assign err_set = tick_i & quad & ab_en_i & illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_pv_q  <= 1'b0;
      b_pv_q  <= 1'b0;
      a_raw_q <= 1'b0;
      cnt_q   <= 1'b0;
      up_q    <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= 1'b0;
      evt_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      a_raw_q <= a_raw_i;
      if (tick_i) begin
        a_pv_q <= a_flt_i;
        b_pv_q <= b_flt_i;
        idx_q  <= act;
      end
      if (quad) begin
        if (tick_i) begin
          cnt_q   <= q_cnt;
          if (q_cnt) up_q <= dir;
          evt_q   <= q_evt;
          fired_q <= act & (fired_q | q_evt);
        end
      end else begin
        cnt_q   <= d_cnt;
        if (d_cnt) up_q <= b_raw_i;
        evt_q   <= 1'b0;
        fired_q <= 1'b0;
      end
      // set wins over a simultaneous clear
      if (err_set)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign count_o   = cnt_q;
  assign up_o      = up_q;
  assign err_o     = err_q;
  assign idx_o     = idx_q;
  assign idx_evt_o = evt_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && quad) |=> $stable(count_o));

  // R6
  illegal_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && quad && illegal) |=> !count_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  // R9
  ab_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en_i && (tick_i || !quad)) |=> !count_o);

  // R9
  ab_off_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en_i && !err_o) |=> !err_o);

  // R11
  evt_with_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_evt_o |-> count_o);
endmodule

// File: rtl/quad_filter_decoder.sv
module quad_filter_decoder
  import qdf_pkg::*;
#(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psc_load_i,
  input  logic [PSC_W-1:0] psc_val_i,
  input  logic [1:0]       mode_i,
  input  logic             ab_en_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             idx_i,
  input  logic             idx_en_i,
  input  logic             idx_pol_i,
  input  logic             err_clr_i,
  output logic             count_o,
  output logic             up_o,
  output logic             err_o,
  output logic             idx_o,
  output logic             idx_evt_o
);
  logic              tick;
  logic [NUM_CH-1:0] raw, flt;

  assign raw[CH_A]   = a_i;
  assign raw[CH_B]   = b_i;
  assign raw[CH_IDX] = idx_i;

  qdf_prescaler #(.W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (psc_load_i),
    .value_i (psc_val_i),
    .tick_o  (tick)
  );

  qdf_glitch_filter #(.N(NUM_CH)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .raw_i  (raw),
    .flt_o  (flt)
  );

  qdf_decoder u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (qmode_e'(mode_i)),
    .ab_en_i   (ab_en_i),
    .a_raw_i   (a_i),
    .b_raw_i   (b_i),
    .a_flt_i   (flt[CH_A]),
    .b_flt_i   (flt[CH_B]),
    .idx_flt_i (flt[CH_IDX]),
    .idx_en_i  (idx_en_i),
    .idx_pol_i (idx_pol_i),
    .err_clr_i (err_clr_i),
    .count_o   (count_o),
    .up_o      (up_o),
    .err_o     (err_o),
    .idx_o     (idx_o),
    .idx_evt_o (idx_evt_o)
  );
endmodule

// File: tb/quad_filter_decoder_test.sv
module quad_filter_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psc_load = 1'b0;
  logic [7:0] psc_val = 8'd0;
  logic [1:0] mode = 2'b11;
  logic ab_en = 1'b1, a = 1'b0, b = 1'b0, idx = 1'b0;
  logic idx_en = 1'b0, idx_pol = 1'b1, err_clr = 1'b0;
  logic count, up, err, idx_lvl, evt;

  quad_filter_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .psc_load_i(psc_load), .psc_val_i(psc_val),
    .mode_i(mode), .ab_en_i(ab_en), .a_i(a), .b_i(b), .idx_i(idx),
    .idx_en_i(idx_en), .idx_pol_i(idx_pol), .err_clr_i(err_clr),
    .count_o(count), .up_o(up), .err_o(err), .idx_o(idx_lvl), .idx_evt_o(evt)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_n = 0, m_div = 0;
  bit m_smp[3], m_flt[3];
  bit m_pa = 0, m_pb = 0, m_araw = 0;
  bit m_cnt = 0, m_up = 0, m_err = 0, m_idx = 0, m_evt = 0, m_fired = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_div = 0; m_pa = 0; m_pb = 0; m_araw = 0;
      m_cnt = 0; m_up = 0; m_err = 0; m_idx = 0; m_evt = 0; m_fired = 0;
      for (int i = 0; i < 3; i++) begin m_smp[i] = 0; m_flt[i] = 0; end
    end else begin
      bit tk, ch_a, ch_b, dirn, c, act, e, cd, eset;
      bit rawv[3];
      rawv[0] = a; rawv[1] = b; rawv[2] = idx;
      tk   = (m_div == 0);
      ch_a = m_flt[0] != m_pa;
      ch_b = m_flt[1] != m_pb;
      dirn = ch_a ? (m_flt[0] != m_flt[1]) : (m_flt[0] == m_flt[1]);
      case (mode)
        2'b11: c = ch_a != ch_b;
        2'b10: c = ch_a && !ch_b;
        2'b01: c = ch_a && !ch_b && !m_flt[1];
        default: c = 0;
      endcase
      c = c && ab_en;
      act = idx_pol ? m_flt[2] : !m_flt[2];
      e = idx_en && act && c && !m_fired;
      cd = ab_en && a && !m_araw;
      eset = tk && mode != 2'b00 && ab_en && ch_a && ch_b;
      if (mode != 2'b00) begin
        if (tk) begin
          m_cnt = c;
          if (c) m_up = dirn;
          m_evt = e;
          m_fired = act && (m_fired || e);
        end
      end else begin
        m_cnt = cd;
        if (cd) m_up = b;
        m_evt = 0;
        m_fired = 0;
      end
      if (eset) m_err = 1; else if (err_clr) m_err = 0;
      if (tk) begin
        m_idx = act;
        m_pa = m_flt[0];
        m_pb = m_flt[1];
        for (int i = 0; i < 3; i++) begin
          if (rawv[i] == m_smp[i]) m_flt[i] = rawv[i];
          m_smp[i] = rawv[i];
        end
      end
      m_araw = a;
      if (psc_load) begin m_n = psc_val; m_div = psc_val; end
      else if (tk) m_div = m_n;
      else m_div = m_div - 1;
    end
  end

  // per-cycle comparison and event counting
  int n_up = 0, n_dn = 0, n_evt = 0, cur_w = 0, last_w = 0;
  bit p_cnt = 0, p_evt = 0;

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, "count_o", count, m_cnt);
      chk(cur_req, "up_o", up, m_up);
      chk(cur_req, "err_o", err, m_err);
      chk(cur_req, "idx_o", idx_lvl, m_idx);
      chk(cur_req, "idx_evt_o", evt, m_evt);
      if (count && !p_cnt) begin if (up) n_up++; else n_dn++; end
      if (evt && !p_evt) n_evt++;
      if (count) cur_w++;
      else if (p_cnt) begin last_w = cur_w; cur_w = 0; end
      p_cnt = count; p_evt = evt;
    end
  end

  task automatic clr_counts();
    n_up = 0; n_dn = 0; n_evt = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int g = 0;
  task automatic qstep(int d);
    g = (g + d) & 3;
    @(negedge clk);
    a = (g == 1 || g == 2);
    b = (g == 2 || g == 3);
    wait_cyc(11);
  endtask

  task automatic load_psc(int v);
    @(negedge clk); psc_load = 1; psc_val = 8'(v);
    @(negedge clk); psc_load = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    #1;
    chk("R1", "reset count_o", count, 0);
    chk("R7", "reset err_o", err, 0);
    chk("R11", "reset idx_evt_o", evt, 0);

    // R1: divider width visible as pulse width
    cur_req = "R1";
    load_psc(3);
    wait_cyc(8);
    qstep(1);
    wait_cyc(12);
    chk("R1", "count width n=3", last_w, 4);
    load_psc(1);
    wait_cyc(8);
    qstep(1);
    wait_cyc(8);
    chk("R1", "count width n=1", last_w, 2);
    qstep(-1); qstep(-1);
    wait_cyc(12);

    // R3: x4
    cur_req = "R3";
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(1);
    wait_cyc(12);
    chk("R3", "x4 fwd up", n_up, 8);
    chk("R3", "x4 fwd dn", n_dn, 0);
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(-1);
    wait_cyc(12);
    chk("R3", "x4 rev dn", n_dn, 8);
    chk("R3", "x4 rev up", n_up, 0);

    // R4: x2
    cur_req = "R4";
    mode = 2'b10;
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(1);
    wait_cyc(12);
    chk("R4", "x2 fwd up", n_up, 4);
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(-1);
    wait_cyc(12);
    chk("R4", "x2 rev dn", n_dn, 4);

    // R5: x1
    cur_req = "R5";
    mode = 2'b01;
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(1);
    wait_cyc(12);
    chk("R5", "x1 fwd up", n_up, 2);
    clr_counts();
    for (int i = 0; i < 8; i++) qstep(-1);
    wait_cyc(12);
    chk("R5", "x1 rev dn", n_dn, 2);
    chk("R5", "x1 rev up", n_up, 0);

    // R2: short glitches rejected
    cur_req = "R2";
    mode = 2'b11;
    clr_counts();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); a = 1;
      @(negedge clk); a = 0;
      wait_cyc(3 + i);
    end
    wait_cyc(12);
    chk("R2", "glitch counts", n_up + n_dn, 0);

    // R6 / R7: illegal transition and sticky flag
    cur_req = "R6";
    clr_counts();
    @(negedge clk); a = 1; b = 1;
    wait_cyc(20);
    chk("R6", "err after illegal", err, 1);
    chk("R6", "no count on illegal", n_up + n_dn, 0);
    cur_req = "R7";
    wait_cyc(30);
    chk("R7", "err held", err, 1);
    pulse_clr();
    #1;
    chk("R7", "err cleared", err, 0);
    @(negedge clk); a = 0; b = 0;
    wait_cyc(20);
    pulse_clr();
    // collision sweep: clear pulse at varying offsets to the decode tick
    for (int off = 0; off < 8; off++) begin
      @(negedge clk); a = ~a; b = ~b;
      wait_cyc(off);
      pulse_clr();
      wait_cyc(16);
      pulse_clr();
    end
    a = 0; b = 0;
    wait_cyc(20);
    pulse_clr();
    g = 0;

    // R9: inputs disabled
    cur_req = "R9";
    ab_en = 0;
    clr_counts();
    for (int i = 0; i < 4; i++) qstep(1);
    @(negedge clk); a = 1; b = 1;
    wait_cyc(20);
    chk("R9", "disabled counts", n_up + n_dn, 0);
    chk("R9", "disabled err", err, 0);
    @(negedge clk); a = 0; b = 0;
    wait_cyc(20);
    g = 0;
    ab_en = 1;
    wait_cyc(4);

    // R8: direct mode
    cur_req = "R8";
    mode = 2'b00;
    clr_counts();
    b = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); a = 1; wait_cyc(1);
      @(negedge clk); a = 0; wait_cyc(1);
    end
    b = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); a = 1; wait_cyc(1);
      @(negedge clk); a = 0; wait_cyc(1);
    end
    wait_cyc(4);
    chk("R8", "direct up", n_up, 5);
    chk("R8", "direct dn", n_dn, 3);
    chk("R8", "direct width", last_w, 1);
    wait_cyc(20);

    // R10: index level and polarity
    cur_req = "R10";
    mode = 2'b11;
    @(negedge clk); idx = 1;
    wait_cyc(12);
    chk("R10", "idx pos active", idx_lvl, 1);
    idx_pol = 0;
    wait_cyc(6);
    chk("R10", "idx neg inactive", idx_lvl, 0);
    @(negedge clk); idx = 0;
    wait_cyc(12);
    chk("R10", "idx neg active", idx_lvl, 1);
    idx_pol = 1;
    wait_cyc(12);

    // R11: synchronised index event
    cur_req = "R11";
    idx_en = 1;
    clr_counts();
    qstep(1);
    idx = 1; qstep(1);
    idx = 0; qstep(1);
    qstep(1);
    wait_cyc(12);
    chk("R11", "quarter-cycle events", n_evt, 1);
    clr_counts();
    idx = 1; qstep(1);
    qstep(1);
    idx = 0; qstep(1);
    qstep(1);
    wait_cyc(12);
    chk("R11", "half-cycle events", n_evt, 1);
    idx_en = 0;
    clr_counts();
    idx = 1; qstep(1);
    idx = 0; qstep(1);
    wait_cyc(12);
    chk("R11", "disabled events", n_evt, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule